// File: doc/BRIEF.md
# Outstanding Transaction Table for a Split-Transaction Bus

This block sits in the bus interface of every cache controller on a split-transaction bus. It keeps one entry for each transaction that has won the address bus and has not yet received its data. The bus gives each winning request a small tag, and every controller on the bus writes that request into the entry selected by the tag. As a result, all copies of the table hold the same contents at the same index. Each entry stores the block address, the kind of request, whether this controller issued it, and this cache's snoop state for the block once that state is known.

The table answers three kinds of question, and it answers all of them within the same cycle.
- A request that is about to be issued is compared against every live entry. A request to a block that is already outstanding is flagged as a conflict so that it can be NACKed or held back.
- A processor address is looked up associatively.
- A response carries only a tag. That tag selects the entry whose address and kind describe the returning data. The entry is then released, and its tag becomes free for reuse.

The table also reports the lowest free tag and whether all entries are in use.

The request interface uses valid/ready. A request is written only in a cycle in which `iss_valid` and `iss_ready` are both high. While ready is low the request is not taken, and the issuer must hold its inputs. Responses and snoop-state updates have no back-pressure: the table takes them in every cycle in which their valid is high. All lookup outputs are combinational on the stored state. A write or release becomes visible on the cycle after the edge that performs it.

Top module: `ort_table`

## Requirements
- R1: After reset no entry is valid, `full` is 0, `free_tag` is 0, and `rd_valid`, `rsp_hit` and `cpu_hit` are 0.
- R2: An accepted request writes its address, kind (0 read-shared, 1 read-exclusive, 2 upgrade, 3 writeback) and own-request flag into the entry numbered `iss_tag`. From the next cycle the read port shows that entry as valid with exactly those fields, snoop state not yet known.
- R3: `iss_ready` is 0 while the entry at `iss_tag` is valid, unless a response for that same tag arrives in the same cycle. A request that is not accepted leaves the table unchanged.
- R4: `iss_conflict` is 1 when `iss_addr` equals the address of a valid entry that is not being released in the same cycle. Under conflict `iss_ready` is 0, so no block is ever held by two entries.
- R5: `cpu_hit` is 1 exactly when `cpu_addr` equals the address of a valid entry, and `cpu_tag` then gives that entry's index. `cpu_tag` is 0 on a miss.
- R6: With `rsp_valid` high, `rsp_hit` reflects whether the entry at `rsp_tag` is valid, and `rsp_addr` and `rsp_kind` give that entry's fields. `rsp_mine` is 1 only for a hit on an entry whose own-request flag is set.
- R7: A response releases the entry at its tag from the next cycle on. A response to a tag that is not valid changes nothing, and so does a cycle with no accepted request and no response.
- R8: `free_tag` is the lowest-numbered invalid entry, and `full` is 1 exactly when every entry is valid. `free_tag` is 0 while full.
- R9: When a response and an accepted request name the same tag in one cycle, the release happens first. The entry then holds the new request.
- R10: A snoop-state update on a valid entry stores `snp_state` and marks it known. An update is ignored when the entry is invalid, or when that tag is released or allocated in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Bus-granted request present |
| iss_ready | output | 1 | Request can be recorded this cycle |
| iss_tag | input | TAG_W | Tag assigned to the request |
| iss_addr | input | ADDR_W | Block address of the request |
| iss_kind | input | 2 | Request kind |
| iss_mine | input | 1 | Request was issued by this controller |
| iss_conflict | output | 1 | Request address already outstanding |
| rsp_valid | input | 1 | Response tag present on the data bus |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_hit | output | 1 | Response tag names a valid entry |
| rsp_mine | output | 1 | Response belongs to this controller |
| rsp_addr | output | ADDR_W | Block address of the matched entry |
| rsp_kind | output | 2 | Kind of the matched entry |
| snp_valid | input | 1 | Snoop-state update present |
| snp_tag | input | TAG_W | Entry receiving the snoop state |
| snp_state | input | 2 | Snoop state value |
| cpu_addr | input | ADDR_W | Processor-side lookup address |
| cpu_hit | output | 1 | Processor address is outstanding |
| cpu_tag | output | TAG_W | Entry holding the processor address |
| rd_tag | input | TAG_W | Entry selected for inspection |
| rd_valid | output | 1 | Selected entry is valid |
| rd_addr | output | ADDR_W | Selected entry address |
| rd_kind | output | 2 | Selected entry kind |
| rd_mine | output | 1 | Selected entry own-request flag |
| rd_snp_known | output | 1 | Selected entry snoop state recorded |
| rd_snp_state | output | 2 | Selected entry snoop state |
| free_tag | output | TAG_W | Lowest free entry index |
| full | output | 1 | All entries valid |

## Verification
A release and an allocation can fall in the same cycle. They may name the same tag, or the response may free a block that a new request names at another tag. A snoop update can also coincide with a release or an allocation of its entry. The bench provokes these collisions directly and then throughout a long pseudo-random phase over a small pool of addresses, so that tag reuse and block conflicts occur often. A bench model judges each collision by applying the snoop update, then the release, then the allocation. It checks `iss_ready` and `iss_conflict` before the edge, and checks the read port and the free tag after it.

// File: rtl/ort_pkg.sv
package ort_pkg;
  typedef enum logic [1:0] {
    KIND_RD_SHARED = 2'd0,
    KIND_RD_EXCL   = 2'd1,
    KIND_UPGRADE   = 2'd2,
    KIND_WRBACK    = 2'd3
  } req_kind_e;

  localparam int unsigned KIND_W = 2;
  localparam int unsigned SNP_W  = 2;
endpackage

// File: rtl/ort_lowbit.sv
module ort_lowbit #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/ort_cam.sv
module ort_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]               key,
  input  logic [ENTRIES-1:0]              vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  addrs,
  output logic [ENTRIES-1:0]              hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = vld[g] && (addrs[g] == key);
  end
endmodule

// File: rtl/ort_store.sv
module ort_store
  import ort_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_en,
  input  logic [TAG_W-1:0]                alloc_tag,
  input  logic [ADDR_W-1:0]               alloc_addr,
  input  logic [KIND_W-1:0]               alloc_kind,
  input  logic                            alloc_mine,
  input  logic                            rel_en,
  input  logic [TAG_W-1:0]                rel_tag,
  input  logic                            snp_en,
  input  logic [TAG_W-1:0]                snp_tag,
  input  logic [SNP_W-1:0]                snp_state,
  output logic [ENTRIES-1:0]              vld_q,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  addr_q,
  output logic [ENTRIES-1:0][KIND_W-1:0]  kind_q,
  output logic [ENTRIES-1:0]              mine_q,
  output logic [ENTRIES-1:0]              known_q,
  output logic [ENTRIES-1:0][SNP_W-1:0]   snp_q
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel_alloc, sel_rel, sel_snp;
    assign sel_alloc = alloc_en && (alloc_tag == TAG_W'(g));
    assign sel_rel   = rel_en   && (rel_tag   == TAG_W'(g));
    assign sel_snp   = snp_en && (snp_tag == TAG_W'(g)) && vld_q[g]
                       && !sel_rel && !sel_alloc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]   <= 1'b0;
        addr_q[g]  <= '0;
        kind_q[g]  <= '0;
        mine_q[g]  <= 1'b0;
        known_q[g] <= 1'b0;
        snp_q[g]   <= '0;
      end else begin
        if (sel_snp) begin
          known_q[g] <= 1'b1;
          snp_q[g]   <= snp_state;
        end
        if (sel_rel) begin
          vld_q[g]   <= 1'b0;
          known_q[g] <= 1'b0;
        end
        if (sel_alloc) begin
          vld_q[g]   <= 1'b1;
          addr_q[g]  <= alloc_addr;
          kind_q[g]  <= alloc_kind;
          mine_q[g]  <= alloc_mine;
          known_q[g] <= 1'b0;
          snp_q[g]   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ort_table.sv
module ort_table
  import ort_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [1:0]        iss_kind,
  input  logic              iss_mine,
  output logic              iss_conflict,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_hit,
  output logic              rsp_mine,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_kind,
  input  logic              snp_valid,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [1:0]        snp_state,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_hit,
  output logic [TAG_W-1:0]  cpu_tag,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_kind,
  output logic              rd_mine,
  output logic              rd_snp_known,
  output logic [1:0]        rd_snp_state,
  output logic [TAG_W-1:0]  free_tag,
  output logic              full
);
  logic [ENTRIES-1:0]              vld_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]  addr_q;
  logic [ENTRIES-1:0][KIND_W-1:0]  kind_q;
  logic [ENTRIES-1:0]              mine_q;
  logic [ENTRIES-1:0]              known_q;
  logic [ENTRIES-1:0][SNP_W-1:0]   snp_q;

  logic [ENTRIES-1:0] rel_vec;
  logic [ENTRIES-1:0] iss_hits;
  logic [ENTRIES-1:0] cpu_hits;
  logic               slot_free;
  logic               alloc_en;
  logic               any_free;

  assign rel_vec   = rsp_valid ? (ENTRIES'(1) << rsp_tag) : '0;
  assign slot_free = !vld_q[iss_tag] || rel_vec[iss_tag];

  ort_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_iss_cam (
    .key(iss_addr), .vld(vld_q), .addrs(addr_q), .hits(iss_hits)
  );

  ort_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cpu_cam (
    .key(cpu_addr), .vld(vld_q), .addrs(addr_q), .hits(cpu_hits)
  );

  assign iss_conflict = |(iss_hits & ~rel_vec);
  assign iss_ready    = slot_free && !iss_conflict;
  assign alloc_en     = iss_valid && iss_ready;

  ort_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_tag(iss_tag), .alloc_addr(iss_addr),
    .alloc_kind(iss_kind), .alloc_mine(iss_mine),
    .rel_en(rsp_valid), .rel_tag(rsp_tag),
    .snp_en(snp_valid), .snp_tag(snp_tag), .snp_state(snp_state),
    .vld_q(vld_q), .addr_q(addr_q), .kind_q(kind_q), .mine_q(mine_q),
    .known_q(known_q), .snp_q(snp_q)
  );

  ort_lowbit #(.W(ENTRIES)) u_free_pick (
    .vec(~vld_q), .idx(free_tag), .any(any_free)
  );
  assign full = !any_free;

  ort_lowbit #(.W(ENTRIES)) u_cpu_pick (
    .vec(cpu_hits), .idx(cpu_tag), .any(cpu_hit)
  );

  assign rsp_hit  = rsp_valid && vld_q[rsp_tag];
  assign rsp_mine = rsp_hit && mine_q[rsp_tag];
  assign rsp_addr = addr_q[rsp_tag];
  assign rsp_kind = kind_q[rsp_tag];

  assign rd_valid     = vld_q[rd_tag];
  assign rd_addr      = addr_q[rd_tag];
  assign rd_kind      = kind_q[rd_tag];
  assign rd_mine      = mine_q[rd_tag];
  assign rd_snp_known = known_q[rd_tag];
  assign rd_snp_state = snp_q[rd_tag];
endmodule

// File: rtl/ort_table_chk.sv
module ort_table_chk #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] cpu_hits,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [TAG_W-1:0]   iss_tag,
  input logic               iss_conflict,
  input logic               rsp_valid,
  input logic [TAG_W-1:0]   rsp_tag,
  input logic [TAG_W-1:0]   free_tag,
  input logic               full
);
  // R4
  conflict_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_conflict |-> !iss_ready);

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_hits));

  // R2
  alloc_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> vld[$past(iss_tag)]);

  // R7
  release_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(iss_valid && iss_ready && iss_tag == rsp_tag))
      |=> !vld[$past(rsp_tag)]);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !(iss_valid && iss_ready)) |=> $stable(vld));

  // R8
  free_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !vld[free_tag]);
endmodule

bind ort_table ort_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vld(vld_q), .cpu_hits(cpu_hits),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
  .iss_conflict(iss_conflict), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .free_tag(free_tag), .full(full)
);

// File: tb/ort_table_tb.sv
module ort_table_tb;
  localparam int E  = 8;
  localparam int TW = 3;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          iss_valid = 0, iss_mine = 0, rsp_valid = 0, snp_valid = 0;
  logic [TW-1:0] iss_tag = 0, rsp_tag = 0, snp_tag = 0, rd_tag = 0;
  logic [AW-1:0] iss_addr = 0, cpu_addr = 0;
  logic [1:0]    iss_kind = 0, snp_state = 0;
  logic          iss_ready, iss_conflict, rsp_hit, rsp_mine, cpu_hit;
  logic          rd_valid, rd_mine, rd_snp_known, full;
  logic [AW-1:0] rsp_addr, rd_addr;
  logic [1:0]    rsp_kind, rd_kind, rd_snp_state;
  logic [TW-1:0] cpu_tag, free_tag;

  ort_table #(.ENTRIES(E), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .iss_addr(iss_addr), .iss_kind(iss_kind), .iss_mine(iss_mine),
    .iss_conflict(iss_conflict),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit),
    .rsp_mine(rsp_mine), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_state(snp_state),
    .cpu_addr(cpu_addr), .cpu_hit(cpu_hit), .cpu_tag(cpu_tag),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_kind(rd_kind), .rd_mine(rd_mine), .rd_snp_known(rd_snp_known),
    .rd_snp_state(rd_snp_state), .free_tag(free_tag), .full(full)
  );

  // Model of the table
  bit          m_vld [E];
  logic [AW-1:0] m_addr [E];
  logic [1:0]  m_kind [E];
  bit          m_mine [E];
  bit          m_known [E];
  logic [1:0]  m_snp [E];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pool(input int k);
    return 32'h0000_2000 + 32'(k) * 32'h40;
  endfunction

  // Compare every combinational output against the model, then clock.
  task automatic tick();
    bit exp_conf, exp_free_slot, exp_ready, exp_full, exp_chit;
    int exp_ftag, exp_ctag;
    #1;
    exp_conf = 0;
    for (int j = 0; j < E; j++)
      if (m_vld[j] && m_addr[j] == iss_addr && !(rsp_valid && rsp_tag == j[TW-1:0]))
        exp_conf = 1;
    exp_free_slot = !m_vld[iss_tag] || (rsp_valid && rsp_tag == iss_tag);
    exp_ready = exp_free_slot && !exp_conf;
    chk(iss_conflict == exp_conf, "R4", "iss_conflict", 32'(iss_conflict), 32'(exp_conf));
    chk(iss_ready == exp_ready, "R3", "iss_ready", 32'(iss_ready), 32'(exp_ready));
    exp_full = 1; exp_ftag = 0;
    for (int j = E - 1; j >= 0; j--) if (!m_vld[j]) begin exp_full = 0; exp_ftag = j; end
    chk(full == exp_full, "R8", "full", 32'(full), 32'(exp_full));
    chk(free_tag == exp_ftag[TW-1:0], "R8", "free_tag", 32'(free_tag), 32'(exp_ftag));
    exp_chit = 0; exp_ctag = 0;
    for (int j = E - 1; j >= 0; j--)
      if (m_vld[j] && m_addr[j] == cpu_addr) begin exp_chit = 1; exp_ctag = j; end
    chk(cpu_hit == exp_chit, "R5", "cpu_hit", 32'(cpu_hit), 32'(exp_chit));
    chk(cpu_tag == exp_ctag[TW-1:0], "R5", "cpu_tag", 32'(cpu_tag), 32'(exp_ctag));
    chk(rsp_hit == (rsp_valid && m_vld[rsp_tag]), "R6", "rsp_hit",
        32'(rsp_hit), 32'(rsp_valid && m_vld[rsp_tag]));
    chk(rsp_mine == (rsp_valid && m_vld[rsp_tag] && m_mine[rsp_tag]), "R6", "rsp_mine",
        32'(rsp_mine), 32'(rsp_valid && m_vld[rsp_tag] && m_mine[rsp_tag]));
    if (rsp_valid && m_vld[rsp_tag]) begin
      chk(rsp_addr == m_addr[rsp_tag], "R6", "rsp_addr", rsp_addr, m_addr[rsp_tag]);
      chk(rsp_kind == m_kind[rsp_tag], "R6", "rsp_kind", 32'(rsp_kind), 32'(m_kind[rsp_tag]));
    end
    chk(rd_valid == m_vld[rd_tag], "R7", "rd_valid", 32'(rd_valid), 32'(m_vld[rd_tag]));
    if (m_vld[rd_tag]) begin
      chk(rd_addr == m_addr[rd_tag], "R2", "rd_addr", rd_addr, m_addr[rd_tag]);
      chk(rd_kind == m_kind[rd_tag], "R2", "rd_kind", 32'(rd_kind), 32'(m_kind[rd_tag]));
      chk(rd_mine == m_mine[rd_tag], "R2", "rd_mine", 32'(rd_mine), 32'(m_mine[rd_tag]));
      chk(rd_snp_known == m_known[rd_tag], "R10", "rd_snp_known",
          32'(rd_snp_known), 32'(m_known[rd_tag]));
      if (m_known[rd_tag])
        chk(rd_snp_state == m_snp[rd_tag], "R10", "rd_snp_state",
            32'(rd_snp_state), 32'(m_snp[rd_tag]));
    end
    @(posedge clk);
    // Model update: snoop, then release, then allocation (R9, R10)
    if (snp_valid && m_vld[snp_tag] && !(rsp_valid && rsp_tag == snp_tag)
        && !(iss_valid && exp_ready && iss_tag == snp_tag)) begin
      m_known[snp_tag] = 1; m_snp[snp_tag] = snp_state;
    end
    if (rsp_valid) begin m_vld[rsp_tag] = 0; m_known[rsp_tag] = 0; end
    if (iss_valid && exp_ready) begin
      m_vld[iss_tag] = 1; m_addr[iss_tag] = iss_addr; m_kind[iss_tag] = iss_kind;
      m_mine[iss_tag] = iss_mine; m_known[iss_tag] = 0; m_snp[iss_tag] = 0;
    end
    @(negedge clk);
    iss_valid = 0; rsp_valid = 0; snp_valid = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    for (int j = 0; j < E; j++) begin
      m_vld[j] = 0; m_addr[j] = 0; m_kind[j] = 0; m_mine[j] = 0; m_known[j] = 0; m_snp[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk(!full, "R1", "full", 32'(full), 0);
    chk(free_tag == 0, "R1", "free_tag", 32'(free_tag), 0);
    chk(!rd_valid && !rsp_hit && !cpu_hit, "R1", "valid flags",
        32'({rd_valid, rsp_hit, cpu_hit}), 0);
    tick();

    // R2 fill all tags in scrambled order
    for (int i = 0; i < E; i++) begin
      iss_valid = 1; iss_tag = TW'((i * 3 + 5) % E); iss_addr = pool(i);
      iss_kind = 2'(i % 4); iss_mine = i[0]; cpu_addr = pool(i); rd_tag = TW'(i);
      tick();
    end
    chk(full, "R8", "full after fill", 32'(full), 1);

    // R3 occupied slot refuses a fresh address
    iss_valid = 1; iss_tag = 3; iss_addr = 32'hDEAD_0000; rd_tag = 3;
    tick();
    chk(rd_addr != 32'hDEAD_0000, "R3", "refused write", rd_addr, m_addr[3]);

    // R10 snoop sweep, R5 lookups
    for (int t = 0; t < E; t++) begin
      snp_valid = 1; snp_tag = TW'(t); snp_state = 2'((t + 1) % 4);
      rd_tag = TW'(t); cpu_addr = pool(t + 2);
      tick();
    end
    for (int t = 0; t < E; t++) begin rd_tag = TW'(t); tick(); end

    // R4 conflict with a live block while the slot is being released
    rsp_valid = 1; rsp_tag = 2; iss_valid = 1; iss_tag = 2; iss_addr = m_addr[5]; rd_tag = 2;
    tick();
    chk(!rd_valid, "R7", "released entry", 32'(rd_valid), 0);
    iss_valid = 1; iss_tag = 2; iss_addr = m_addr[5];
    tick();
    // R4 block being released at tag 5 may be reissued at tag 2
    rsp_valid = 1; rsp_tag = 5; iss_valid = 1; iss_tag = 2; iss_addr = m_addr[5]; rd_tag = 2;
    tick();
    chk(rd_valid, "R4", "reissue of released block", 32'(rd_valid), 1);
    // R9 release and allocate the same tag
    rsp_valid = 1; rsp_tag = 2; iss_valid = 1; iss_tag = 2; iss_addr = 32'h0000_9980;
    iss_kind = 2'd1; iss_mine = 1; rd_tag = 2;
    tick();
    chk(rd_valid && rd_addr == 32'h0000_9980, "R9", "same-tag replace", rd_addr, 32'h0000_9980);
    // R10 snoop on an invalid entry is ignored
    snp_valid = 1; snp_tag = 5; snp_state = 2'd3;
    tick();
    iss_valid = 1; iss_tag = 5; iss_addr = 32'h0000_7700; rd_tag = 5;
    tick();
    chk(!rd_snp_known, "R10", "snoop on invalid", 32'(rd_snp_known), 0);
    // R10 snoop together with release
    snp_valid = 1; snp_tag = 0; rsp_valid = 1; rsp_tag = 0;
    tick();
    // R7 response to an invalid tag
    rsp_valid = 1; rsp_tag = 0; rd_tag = 0;
    tick();
    chk(!rd_valid, "R7", "stray response", 32'(rd_valid), 0);

    // R6 drain out of order
    for (int i = 0; i < E; i++) begin
      rsp_valid = 1; rsp_tag = TW'((i * 5 + 7) % E); rd_tag = TW'((i * 5 + 7) % E);
      tick();
    end
    chk(!full && free_tag == 0, "R8", "empty after drain", 32'(free_tag), 0);

    // Mixed pseudo-random phase over a small address pool
    seed = 32'h1;
    for (int k = 0; k < 3000; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      iss_valid = seed[16]; iss_tag = seed[19:17]; iss_addr = pool(int'(seed[23:20]) % 12);
      iss_kind = seed[25:24]; iss_mine = seed[26];
      rsp_valid = seed[27] & seed[28]; rsp_tag = seed[31:29];
      snp_valid = seed[12]; snp_tag = seed[15:13]; snp_state = seed[11:10];
      cpu_addr = pool(int'(seed[9:6]) % 12); rd_tag = seed[5:3];
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule